// File: doc/BRIEF.md
# I2S master clock generator

This block generates the two serial audio clocks of a two-channel I2S master: the bit clock and the left/right frame clock. It runs on the system clock. Each of the two audio master clock sources arrives as a one-cycle tick, and every tick marks one master-clock edge. A select bit picks which tick stream is counted. A 4-bit code picks the division ratio from a fixed table that mixes powers of two with multiples of six. Each bit-clock half period lasts `ratio` selected ticks, so the bit clock runs at the master clock frequency divided by the ratio.

A frame has two slots of 32 bit clocks each, left first, so the bit clock is 64 times the sample rate. Polarity bits can invert either output clock. The block drives its clocks only in master mode. It runs while transmit or receive is enabled, or while the continue bit asks the frame clock to keep going during idle. The serializers get a one-cycle strobe at the start of every slot, with a left/right tag, and a separate strobe at the start of every frame.

Configuration is copied into an active set while the generator is stopped, and only at a frame boundary while it runs. A stop request is honoured only at a frame boundary, so the clocks never produce runt pulses. Dropping master mode releases the clocks at once.

Top module: `i2s_clkgen`

## Requirements
- R1: Codes 0..7 select ratios 1,2,4,8,16,32,64,128. Codes 8..12 select ratios 6,12,24,48,96. While running, `bclk_o` changes level once per `ratio` selected ticks.
- R2: Codes 13..15 are invalid. Once such a code is adopted, `cfg_err_o` is 1 and the clocks do not start. Adopting a valid code clears `cfg_err_o`.
- R3: A frame is 128 bit-clock half periods: 32 bit clocks per slot, left slot then right slot. With `lrclk_pol_i`=0, `lrclk_o` is 0 during the left slot and 1 during the right slot. Both clock levels change together on the bit-clock edge that starts a slot.
- R4: `src_sel_i`=0 counts `mclk_a_tick`. `src_sel_i`=1 counts `mclk_b_tick`.
- R5: `bclk_pol_i`=1 inverts `bclk_o`, which includes its idle level (idle is 1 instead of 0).
- R6: `lrclk_pol_i`=1 inverts `lrclk_o`, so the left slot is high.
- R7: The generator runs while `master_i` is 1, the code is valid, and at least one of `tx_en_i`, `rx_en_i`, `cont_i` is 1. When all three are 0, it stops at the next frame boundary and rests at the idle levels.
- R8: `master_i`=0 sets `clk_oe_o`, `bclk_o` and `lrclk_o` to 0 on the next cycle. The frame position returns to the start of the left slot.
- R9: While running, changes to the code, the source select or the polarities take effect only at a frame boundary.
- R10: `slot_stb_o` is high for exactly one cycle at the start of each slot. `slot_right_o` is 1 for the right slot. `frame_stb_o` pulses only with a left-slot strobe, which makes two slot strobes per frame.
- R11: After reset all outputs are 0 and the active code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mclk_a_tick | input | 1 | Edge tick of master clock source A |
| mclk_b_tick | input | 1 | Edge tick of master clock source B |
| src_sel_i | input | 1 | Source select (0 = A, 1 = B) |
| div_code_i | input | 4 | Division ratio code |
| bclk_pol_i | input | 1 | Bit-clock inversion |
| lrclk_pol_i | input | 1 | Frame-clock inversion |
| master_i | input | 1 | Master mode: drive the clocks |
| tx_en_i | input | 1 | Transmit enabled |
| rx_en_i | input | 1 | Receive enabled |
| cont_i | input | 1 | Keep clocks running while datapath is idle |
| bclk_o | output | 1 | Bit clock |
| lrclk_o | output | 1 | Left/right frame clock |
| clk_oe_o | output | 1 | Clock output enable |
| slot_stb_o | output | 1 | One-cycle slot start strobe |
| slot_right_o | output | 1 | Tag of the slot last started (1 = right) |
| frame_stb_o | output | 1 | One-cycle frame start strobe |
| cfg_err_o | output | 1 | Adopted division code is invalid |

## Verification
Two things can fall in the same cycle: the frame wrap that adopts new configuration, and a stop or start decision. A third is a master-mode drop that lands on a divider edge. With ratio 1 and the A source ticking every cycle, a wrap comes every 128 cycles. Changes to the code, the polarities and the enables are made mid-frame, so their adoption, the stop and the restart all land on wrap edges. The bench judges every cycle against a behavioural model kept in integers, and adds directed measurements of half periods and frame lengths before and after each adoption.

// File: rtl/i2s_clkgen_pkg.sv
// Package: shared ratio-table helpers for the I2S master clock generator.
// Assumes a 4-bit code; codes above the last table entry are invalid.
package i2s_clkgen_pkg;

    localparam int CODE_W    = 4;
    localparam int RATIO_W   = 8;
    localparam int POW2_LAST = 7;   // last power-of-two code
    localparam int CODE_LAST = 12;  // last valid code

    // True when the code selects a table entry.
    function automatic logic code_valid(input logic [CODE_W-1:0] code);
        return (int'(code) <= CODE_LAST);
    endfunction

    // Ratio for a code; powers of two first, then six times a power of two.
    function automatic logic [RATIO_W-1:0] code_ratio(input logic [CODE_W-1:0] code);
        logic [RATIO_W-1:0] r;
        if (int'(code) <= POW2_LAST)
            r = RATIO_W'(1) << code;
        else if (int'(code) <= CODE_LAST)
            r = RATIO_W'(6) << (code - CODE_W'(POW2_LAST + 1));
        else
            r = '0;
        return r;
    endfunction

endpackage

// File: rtl/i2s_ratio_decode.sv
// Module: maps the active division code onto its ratio and a validity flag.
// Assumes the code is stable while the divider runs (held by the top).
module i2s_ratio_decode
    import i2s_clkgen_pkg::*;
(
    input  logic [CODE_W-1:0]  code_i,
    output logic [RATIO_W-1:0] ratio_o,
    output logic               valid_o
);

    // Table lookup through the package helpers.
    always_comb begin
        ratio_o = code_ratio(code_i);
        valid_o = code_valid(code_i);
    end

endmodule

// File: rtl/i2s_tick_div.sv
// Module: counts selected master-clock ticks and emits one edge pulse per
// ratio ticks. Assumes ratio_i is non-zero whenever run_i is high.
module i2s_tick_div #(
    parameter int RATIO_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_i,
    input  logic               tick_i,
    input  logic [RATIO_W-1:0] ratio_i,
    output logic               edge_o
);

    logic [RATIO_W-1:0] tcnt_q;

    // Edge when the last tick of a half period arrives.
    always_comb begin
        edge_o = run_i && tick_i && (tcnt_q == ratio_i - 1'b1);
    end

    // Tick counter, cleared while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tcnt_q <= '0;
        else if (!run_i)
            tcnt_q <= '0;
        else if (tick_i)
            tcnt_q <= edge_o ? '0 : tcnt_q + 1'b1;
    end

    // Counter stays inside the half period of the active ratio.
    assert_cnt_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (tcnt_q < ratio_i));

endmodule

// File: rtl/i2s_frame_seq.sv
// Module: half-bit position counter across one frame plus slot/frame strobes.
// Assumes a frame of 2^HALF_W half bits split into two equal slots.
module i2s_frame_seq #(
    parameter int HALF_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_d_i,
    input  logic              start_i,
    input  logic              edge_i,
    output logic [HALF_W-1:0] hcnt_o,
    output logic              wrap_o,
    output logic              slot_stb_o,
    output logic              slot_right_o,
    output logic              frame_stb_o
);

    logic [HALF_W-1:0] hcnt_q;
    logic [HALF_W-1:0] hcnt_inc;
    logic              stb_d;
    logic              side_d;

    // Next position, end-of-frame detect and strobe decision.
    always_comb begin
        hcnt_inc = hcnt_q + 1'b1;
        wrap_o   = edge_i && (hcnt_q == '1);
        stb_d    = run_d_i && (start_i || (edge_i && (hcnt_inc[HALF_W-2:0] == '0)));
        side_d   = start_i ? 1'b0 : hcnt_inc[HALF_W-1];
        hcnt_o   = hcnt_q;
    end

    // Position register: cleared when not running next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hcnt_q <= '0;
        else if (!run_d_i)
            hcnt_q <= '0;
        else if (edge_i)
            hcnt_q <= hcnt_inc;
    end

    // Registered strobes and slot tag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_stb_o   <= 1'b0;
            slot_right_o <= 1'b0;
            frame_stb_o  <= 1'b0;
        end else begin
            slot_stb_o  <= stb_d;
            frame_stb_o <= stb_d && !side_d;
            if (stb_d)
                slot_right_o <= side_d;
        end
    end

    assert_stb_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        slot_stb_o |=> !slot_stb_o);

    assert_frame_is_left_R10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb_o |-> (slot_stb_o && !slot_right_o));

    assert_stb_on_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        slot_stb_o |-> (hcnt_q[HALF_W-2:0] == '0));

endmodule

// File: rtl/i2s_clkgen.sv
// Module: I2S master clock generator top. Holds the active configuration,
// decides run/stop at frame boundaries and shapes the output clocks.
// Assumes SLOT_BITS is a power of two and the ticks are synchronous to clk.
module i2s_clkgen #(
    parameter int SLOT_BITS = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mclk_a_tick,
    input  logic       mclk_b_tick,
    input  logic       src_sel_i,
    input  logic [3:0] div_code_i,
    input  logic       bclk_pol_i,
    input  logic       lrclk_pol_i,
    input  logic       master_i,
    input  logic       tx_en_i,
    input  logic       rx_en_i,
    input  logic       cont_i,
    output logic       bclk_o,
    output logic       lrclk_o,
    output logic       clk_oe_o,
    output logic       slot_stb_o,
    output logic       slot_right_o,
    output logic       frame_stb_o,
    output logic       cfg_err_o
);
    import i2s_clkgen_pkg::*;

    localparam int HALF_W = $clog2(4 * SLOT_BITS);

    logic [CODE_W-1:0]  act_code_q;
    logic               act_sel_q;
    logic               act_bpol_q;
    logic               act_lpol_q;
    logic               err_q;
    logic               run_q;
    logic               oe_q;
    logic [RATIO_W-1:0] ratio;
    logic               ratio_ok;
    logic               tick_sel;
    logic               bit_edge;
    logic               wrap;
    logic               adopt;
    logic               want;
    logic               run_d;
    logic               start;
    logic [HALF_W-1:0]  hcnt;

    i2s_ratio_decode u_dec (
        .code_i  (act_code_q),
        .ratio_o (ratio),
        .valid_o (ratio_ok)
    );

    i2s_tick_div #(.RATIO_W(RATIO_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (run_q),
        .tick_i  (tick_sel),
        .ratio_i (ratio),
        .edge_o  (bit_edge)
    );

    i2s_frame_seq #(.HALF_W(HALF_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_d_i      (run_d),
        .start_i      (start),
        .edge_i       (bit_edge),
        .hcnt_o       (hcnt),
        .wrap_o       (wrap),
        .slot_stb_o   (slot_stb_o),
        .slot_right_o (slot_right_o),
        .frame_stb_o  (frame_stb_o)
    );

    // Run decision: adopt when stopped or at a frame wrap; master drop halts.
    always_comb begin
        tick_sel = act_sel_q ? mclk_b_tick : mclk_a_tick;
        adopt    = !run_q || wrap;
        want     = master_i && code_valid(div_code_i) && (tx_en_i || rx_en_i || cont_i);
        if (!master_i)
            run_d = 1'b0;
        else if (adopt)
            run_d = want;
        else
            run_d = run_q;
        start = !run_q && run_d;
    end

    // Active configuration, error flag, run state and output enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_code_q <= '0;
            act_sel_q  <= 1'b0;
            act_bpol_q <= 1'b0;
            act_lpol_q <= 1'b0;
            err_q      <= 1'b0;
            run_q      <= 1'b0;
            oe_q       <= 1'b0;
        end else begin
            oe_q  <= master_i;
            run_q <= run_d;
            if (adopt) begin
                act_code_q <= div_code_i;
                act_sel_q  <= src_sel_i;
                act_bpol_q <= bclk_pol_i;
                act_lpol_q <= lrclk_pol_i;
                err_q      <= !code_valid(div_code_i);
            end
        end
    end

    // Output clocks: polarity applied, forced low when not master.
    always_comb begin
        bclk_o    = oe_q && (hcnt[0] ^ act_bpol_q);
        lrclk_o   = oe_q && (hcnt[HALF_W-1] ^ act_lpol_q);
        clk_oe_o  = oe_q;
        cfg_err_o = err_q;
    end

    assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !wrap) |=> ($stable(act_code_q) && $stable(act_sel_q)
                              && $stable(act_bpol_q) && $stable(act_lpol_q)));

    assert_bad_code_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |-> !run_q);

    assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !master_i |=> (!clk_oe_o && !bclk_o && !lrclk_o && hcnt == '0));

    assert_running_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> ratio_ok);

endmodule

// File: tb/sim_i2s_clkgen.sv
module sim_i2s_clkgen;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_a = 1'b1;
    logic tick_b = 1'b0;
    logic sel = 1'b0, bpol = 1'b0, lpol = 1'b0, master = 1'b0;
    logic tx = 1'b0, rx = 1'b0, cont = 1'b0;
    logic [3:0] code = 4'd0;
    logic bclk, lrclk, oe, stb, right, fstb, err;

    int checks = 0;
    int fails = 0;
    bit chk_on = 1'b0;
    bit done = 1'b0;

    // reference model state
    int m_run, m_code, m_sel, m_bp, m_lp, m_err, m_oe, m_h, m_t, m_stb, m_side, m_fstb;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2s_clkgen u0 (
        .clk(clk), .rst_n(rst_n), .mclk_a_tick(tick_a), .mclk_b_tick(tick_b),
        .src_sel_i(sel), .div_code_i(code), .bclk_pol_i(bpol), .lrclk_pol_i(lpol),
        .master_i(master), .tx_en_i(tx), .rx_en_i(rx), .cont_i(cont),
        .bclk_o(bclk), .lrclk_o(lrclk), .clk_oe_o(oe), .slot_stb_o(stb),
        .slot_right_o(right), .frame_stb_o(fstb), .cfg_err_o(err)
    );

    function automatic int ref_ratio(input int c);
        if (c < 8) return 1 << c;
        if (c < 13) return 6 * (1 << (c - 8));
        return 0;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // source B ticks every second cycle
    always @(negedge clk) tick_b <= ~tick_b;

    // behavioural reference, advanced on each clock
    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_code = 0; m_sel = 0; m_bp = 0; m_lp = 0; m_err = 0;
            m_oe = 0; m_h = 0; m_t = 0; m_stb = 0; m_side = 0; m_fstb = 0;
        end else begin
            int r, tk, e, wr, ad, want, nrun, st, hp, s, sd;
            r    = ref_ratio(m_code);
            tk   = m_sel ? int'(tick_b) : int'(tick_a);
            e    = (m_run && tk && (m_t == r - 1)) ? 1 : 0;
            wr   = (e && m_h == 127) ? 1 : 0;
            ad   = (!m_run || wr) ? 1 : 0;
            want = (master && ref_ratio(int'(code)) != 0 && (tx || rx || cont)) ? 1 : 0;
            nrun = !master ? 0 : (ad ? want : m_run);
            st   = (!m_run && nrun) ? 1 : 0;
            hp   = (m_h + 1) % 128;
            s    = (nrun && (st || (e && (hp % 64) == 0))) ? 1 : 0;
            sd   = st ? 0 : hp / 64;
            if (!m_run) m_t = 0;
            else if (tk) m_t = e ? 0 : m_t + 1;
            if (!nrun) m_h = 0;
            else if (e) m_h = hp;
            if (ad) begin
                m_code = int'(code); m_sel = int'(sel); m_bp = int'(bpol);
                m_lp = int'(lpol); m_err = (ref_ratio(int'(code)) == 0) ? 1 : 0;
            end
            m_oe = int'(master);
            m_stb = s;
            if (s) m_side = sd;
            m_fstb = (s && !sd) ? 1 : 0;
            m_run = nrun;
        end
    end

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (chk_on && !done) begin
            int eb, el;
            eb = m_oe & ((m_h % 2) ^ m_bp);
            el = m_oe & ((m_h / 64) ^ m_lp);
            chk(int'(bclk) == eb, "R1", "bclk", int'(bclk), eb);
            chk(int'(lrclk) == el, "R3", "lrclk", int'(lrclk), el);
            chk(int'(oe) == m_oe, "R8", "clk_oe", int'(oe), m_oe);
            chk(int'(stb) == m_stb, "R10", "slot_stb", int'(stb), m_stb);
            chk(int'(right) == m_side, "R10", "slot_right", int'(right), m_side);
            chk(int'(fstb) == m_fstb, "R10", "frame_stb", int'(fstb), m_fstb);
            chk(int'(err) == m_err, "R2", "cfg_err", int'(err), m_err);
        end
    end

    task automatic half_period(input int exp, input string tag);
        logic prev;
        int n;
        n = 0;
        prev = bclk;
        while (bclk == prev) @(negedge clk);
        prev = bclk;
        while (bclk == prev) begin @(negedge clk); n++; end
        chk(n == exp, tag, "bclk half period", n, exp);
    endtask

    task automatic wait_frame();
        @(negedge clk);
        while (!fstb) @(negedge clk);
    endtask

    task automatic frame_len(input int exp, input int exp_lr, input string tag);
        int n;
        wait_frame();
        chk(int'(lrclk) == exp_lr, tag, "lrclk at left start", int'(lrclk), exp_lr);
        n = 0;
        do begin @(negedge clk); n++; end while (!fstb);
        chk(n == exp, tag, "frame length", n, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(bclk == 0 && lrclk == 0 && oe == 0, "R11", "clocks after reset", int'(bclk|lrclk|oe), 0);
        chk(stb == 0 && fstb == 0 && err == 0, "R11", "flags after reset", int'(stb|fstb|err), 0);
        rst_n = 1'b1;
        chk_on = 1'b1;

        // R1 / R3: ratio 4 from source A
        master = 1; tx = 1; code = 4'd2; sel = 0;
        repeat (4) @(negedge clk);
        half_period(4, "R1");
        frame_len(512, 0, "R3");

        // R9 / R4: change mid-frame, adopted only at the boundary
        repeat (20) @(negedge clk);
        code = 4'd8; sel = 1;
        half_period(4, "R9");
        wait_frame();
        half_period(12, "R4");

        // R5 / R6: polarities at ratio 1
        code = 4'd0; sel = 0; bpol = 1; lpol = 1;
        wait_frame();
        frame_len(128, 1, "R6");

        // R7: continue keeps clocks running, clearing it stops at a boundary
        tx = 0; cont = 1;
        repeat (300) @(negedge clk);
        half_period(1, "R7");
        cont = 0;
        repeat (200) @(negedge clk);
        for (int i = 0; i < 20; i++) begin
            chk(bclk == 1, "R5", "idle bclk inverted", int'(bclk), 1);
            chk(lrclk == 1, "R6", "idle lrclk inverted", int'(lrclk), 1);
            chk(oe == 1, "R7", "still master when stopped", int'(oe), 1);
            @(negedge clk);
        end

        // R2: invalid code holds clocks and flags the error
        code = 4'd14; tx = 1;
        repeat (3) @(negedge clk);
        chk(err == 1, "R2", "cfg_err on code 14", int'(err), 1);
        for (int i = 0; i < 40; i++) begin
            chk(stb == 0 && bclk == 1, "R2", "static with bad code", int'(stb), 0);
            @(negedge clk);
        end
        code = 4'd12;
        repeat (3) @(negedge clk);
        chk(err == 0, "R2", "cfg_err cleared", int'(err), 0);

        // R8: drop master mid-frame
        repeat (500) @(negedge clk);
        master = 0;
        @(negedge clk);
        @(negedge clk);
        chk(oe == 0 && bclk == 0 && lrclk == 0, "R8", "released clocks", int'(oe|bclk|lrclk), 0);

        // R1: sweep every valid code
        bpol = 0; lpol = 0;
        for (int c = 0; c < 13; c++) begin
            master = 0;
            @(negedge clk);
            code = 4'(c); master = 1;
            @(negedge clk);
            half_period(ref_ratio(c), "R1");
        end

        // R10: two slot strobes per frame at ratio 1
        master = 0;
        @(negedge clk);
        code = 4'd0; master = 1;
        wait_frame();
        begin
            int ns;
            ns = 0;
            for (int i = 0; i < 128; i++) begin
                @(negedge clk);
                if (stb) ns++;
            end
            chk(ns == 2, "R10", "slot strobes per frame", ns, 2);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog R7 actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

endmodule